// File: doc/BRIEF.md
# Three-Byte Serial Register Port

This block is a four-wire serial slave that lets a host controller load and read back a bank of seventeen 8-bit control registers. Every transaction is a 24-bit frame, most significant bit first, held inside a low period of the active-low select line. The first byte names the device and carries the direction flag in its lowest bit. The second byte picks a register. The third byte carries the data: for a write it is the new value, and for a read the port returns the register's contents during that byte.

The serial clock does not follow the system clock. The port runs the serial clock, the select line and the data input through a synchronizer chain into the system clock domain. It finds the edges there and does all of its work on the system clock. Each half period of the serial clock must therefore last at least four system clock cycles. The register contents leave the block on a flat bus for the rest of the chip. The data output comes with a separate drive enable, which the pad ring uses as a tristate control.

Top module: `spi_regport`

## Requirements
- R1: After reset, registers 6 to 13 hold 0xFF (full volume) and every other register holds 0x00. The output enable is low.
- R2: Input bits are taken on rising serial clock edges while select is low. A frame whose first byte is 0x08 writes its third byte into the register named by its second byte. The write takes effect when select rises after exactly 24 bits.
- R3: A frame of any length other than 24 bits leaves every register unchanged. Short and long frames are both covered.
- R4: A first byte other than 0x08 or 0x09 leaves every register unchanged, and the output enable stays low for the whole frame.
- R5: A register index of 17 or above is ignored on a write. On a read it returns 0x00.
- R6: A first byte of 0x09 makes the port shift out the named register during the third byte, MSB first. Each bit is launched on a falling serial clock edge. The enable is high from the falling edge after bit 16 until the falling edge after bit 24.
- R7: The output enable stays low during the first two bytes of every frame and whenever select is high.
- R8: A read frame does not change any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, asynchronous, idles low |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out, zero when not enabled |
| spi_miso_oe | output | 1 | Drive enable for the data out pad |
| cfg_regs | output | 136 | Register contents, register i at bits [8i+7:8i] |

## Verification
The bench writes a different value to every register and checks each one at the bus. It then reads them all back through the serial output, where a wrong bit order or a launch one edge late would shift the returned byte by one position. Frames of 23 and 25 bits test the length check. A port that commits on any select release would take these frames as writes.

Two kinds of frame should change nothing: writes with a wrong device byte, and writes to indices above 16. A design that ignored either check would alias these into the real bank. Reads use both valid and invalid device bytes. For these the bench counts every sample where the enable was high outside the data byte, which would catch a port that drives the line during the header.

// File: rtl/spi_rp_pkg.sv
package spi_rp_pkg;
  localparam int BYTE_W      = 8;
  localparam int FRAME_BYTES = 3;
  localparam int FRAME_BITS  = BYTE_W * FRAME_BYTES;
  localparam int DATA_START  = 2 * BYTE_W;
  localparam int CNT_W       = $clog2(FRAME_BITS + 1);

  // device byte: 7-bit identifier followed by the direction flag (1 = read)
  function automatic logic [BYTE_W-1:0] dev_byte(input logic [BYTE_W-2:0] id, input logic rd);
    return {id, rd};
  endfunction
endpackage

// File: rtl/spi_rp_sync.sv
module spi_rp_sync #(
  parameter int         W       = 3,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], d_async[b]};
    end
    assign q_sync[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_rp_frame.sv
module spi_rp_frame
  import spi_rp_pkg::*;
#(
  parameter int              NUM_REGS = 17,
  parameter logic [BYTE_W-1:0] CMD_WR = 8'h08,
  parameter logic [BYTE_W-1:0] CMD_RD = 8'h09
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              cs_s,
  input  logic              mosi_s,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              miso,
  output logic              miso_oe,
  output logic              cs_rise,
  output logic              sck_fall
);
  localparam logic [BYTE_W-1:0] LAST_IDX = BYTE_W'(NUM_REGS - 1);
  localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0]  CNT_DATA = CNT_W'(DATA_START);

  logic                  sck_q, cs_q;
  logic                  sck_rise, cs_fall;
  logic [CNT_W-1:0]      cnt;
  logic                  over;
  logic [FRAME_BITS-1:0] shreg;
  logic [BYTE_W-1:0]     tx;
  logic                  oe;

  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;
  assign cs_fall  = ~cs_s & cs_q;
  assign cs_rise  = cs_s & ~cs_q;

  // complete frame: device byte in the top byte, index in the middle
  assign wr_addr = shreg[2*BYTE_W-1:BYTE_W];
  assign wr_data = shreg[BYTE_W-1:0];
  assign wr_en   = cs_rise && (cnt == CNT_FULL) && !over
                   && (shreg[FRAME_BITS-1:2*BYTE_W] == CMD_WR)
                   && (wr_addr <= LAST_IDX);

  // after 16 bits the index sits in the low byte
  assign rd_addr = shreg[BYTE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
      cnt   <= '0;
      over  <= 1'b0;
      shreg <= '0;
      tx    <= '0;
      oe    <= 1'b0;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_s;
      if (cs_fall) begin
        cnt  <= '0;
        over <= 1'b0;
      end else if (!cs_s && sck_rise) begin
        shreg <= {shreg[FRAME_BITS-2:0], mosi_s};
        if (cnt == CNT_FULL) over <= 1'b1;
        else                 cnt  <= cnt + 1'b1;
      end
      if (cs_s) begin
        oe <= 1'b0;
      end else if (sck_fall) begin
        if (cnt == CNT_DATA && !over) begin
          tx <= rd_data;
          oe <= (shreg[2*BYTE_W-1:BYTE_W] == CMD_RD);
        end else if (cnt > CNT_DATA && cnt < CNT_FULL) begin
          tx <= {tx[BYTE_W-2:0], 1'b0};
        end else begin
          oe <= 1'b0;
        end
      end
    end
  end

  assign miso    = oe & tx[BYTE_W-1];
  assign miso_oe = oe;
endmodule

// File: rtl/spi_rp_bank.sv
module spi_rp_bank
  import spi_rp_pkg::*;
#(
  parameter int              NUM_REGS  = 17,
  parameter int              VOL_FIRST = 6,
  parameter int              VOL_LAST  = 13,
  parameter logic [BYTE_W-1:0] VOL_RESET = 8'hFF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [BYTE_W-1:0]          wr_addr,
  input  logic [BYTE_W-1:0]          wr_data,
  input  logic [BYTE_W-1:0]          rd_addr,
  output logic [BYTE_W-1:0]          rd_data,
  output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);
  logic [BYTE_W-1:0] regs [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [BYTE_W-1:0] INIT =
      (i >= VOL_FIRST && i <= VOL_LAST) ? VOL_RESET : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 regs[i] <= INIT;
      else if (wr_en && wr_addr == BYTE_W'(i))    regs[i] <= wr_data;
    end
    assign regs_flat[i*BYTE_W +: BYTE_W] = regs[i];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_addr == BYTE_W'(i)) rd_data = regs[i];
  end
endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_rp_pkg::*;
#(
  parameter int                NUM_REGS    = 17,
  parameter int                SYNC_STAGES = 2,
  parameter logic [BYTE_W-2:0] CHIP_ID     = 7'h04,
  parameter int                VOL_FIRST   = 6,
  parameter int                VOL_LAST    = 13,
  parameter logic [BYTE_W-1:0] VOL_RESET   = 8'hFF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       spi_sclk,
  input  logic                       spi_cs_n,
  input  logic                       spi_mosi,
  output logic                       spi_miso,
  output logic                       spi_miso_oe,
  output logic [NUM_REGS*BYTE_W-1:0] cfg_regs
);
  logic              sck_s, cs_s, mosi_s;
  logic              wr_en, cs_rise, sck_fall;
  logic [BYTE_W-1:0] wr_addr, wr_data, rd_addr, rd_data;

  spi_rp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_async({spi_sclk, spi_cs_n, spi_mosi}),
    .q_sync({sck_s, cs_s, mosi_s})
  );

  spi_rp_frame #(
    .NUM_REGS(NUM_REGS),
    .CMD_WR(dev_byte(CHIP_ID, 1'b0)),
    .CMD_RD(dev_byte(CHIP_ID, 1'b1))
  ) u_frame (
    .clk(clk), .rst_n(rst_n),
    .sck_s(sck_s), .cs_s(cs_s), .mosi_s(mosi_s),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .miso(spi_miso), .miso_oe(spi_miso_oe),
    .cs_rise(cs_rise), .sck_fall(sck_fall)
  );

  spi_rp_bank #(
    .NUM_REGS(NUM_REGS), .VOL_FIRST(VOL_FIRST),
    .VOL_LAST(VOL_LAST), .VOL_RESET(VOL_RESET)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .regs_flat(cfg_regs)
  );
endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk #(
  parameter int W = 136
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs_s,
  input logic         cs_rise,
  input logic         sck_fall,
  input logic         miso,
  input logic         miso_oe,
  input logic [W-1:0] cfg_regs
);
  // R7: enable off once select has been high for a cycle
  p_quiet_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && $past(cs_s)) |-> !miso_oe);

  // R2: bank contents move only right after select is released
  p_commit_on_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_regs) |-> $past(cs_rise));

  // R6: drive starts on a falling serial clock edge
  p_launch_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miso_oe) |-> $past(sck_fall));

  // R6: the data bit holds between falling edges
  p_hold_between_falls_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_oe && $past(miso_oe) && !$past(sck_fall)) |-> $stable(miso));
endmodule

bind spi_regport spi_regport_chk #(.W(NUM_REGS*8)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_rise(cs_rise),
  .sck_fall(sck_fall), .miso(spi_miso), .miso_oe(spi_miso_oe),
  .cfg_regs(cfg_regs)
);

// File: tb/spi_regport_tb.sv
module spi_regport_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int NREG       = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe;
  logic [NREG*8-1:0] cfg_regs;

  int tot = 0, bad = 0;
  bit done = 0;
  logic [7:0] model [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_regport dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .cfg_regs(cfg_regs)
  );

  task automatic chk(input string req, input int act, input int exp);
    tot++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_bank(input string req);
    for (int i = 0; i < NREG; i++) chk(req, cfg_regs[i*8 +: 8], model[i]);
  endtask

  // shifts vec[n-1:0] MSB first; samples the output before each rising edge
  task automatic xfer(input logic [31:0] vec, input int n,
                      output logic [7:0] rd, output int early, output int data_oe);
    rd = '0; early = 0; data_oe = 0;
    @(negedge clk) spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      spi_sclk = 1'b0;
      spi_mosi = vec[n-1-i];
      repeat (HALF) @(negedge clk);
      if (i >= 16 && i < 24) begin
        if (spi_miso_oe) data_oe++;
        rd = {rd[6:0], spi_miso & spi_miso_oe};
      end else if (i < 16 && spi_miso_oe) early++;
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    spi_sclk = 1'b0;
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; tot++;
      $display("FAIL R2 watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", tot - bad, tot);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int early, doe;
    for (int i = 0; i < NREG; i++) model[i] = (i >= 6 && i <= 13) ? 8'hFF : 8'h00;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk_bank("R1 reset value");
    chk("R1 enable low in reset", spi_miso_oe, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_bank("R1 reset value after release");

    // R2 write every register with a distinct value
    for (int i = 0; i < NREG; i++) begin
      logic [7:0] v = 8'((i * 29 + 7) & 8'hFF);
      xfer({8'h00, 8'h08, 8'(i), v}, 24, rd, early, doe);
      model[i] = v;
      chk("R2 written register", cfg_regs[i*8 +: 8], v);
      chk("R7 no drive on write", early + doe, 0);
      chk("R7 enable low after select", spi_miso_oe, 0);
    end
    chk_bank("R2 bank after sweep");

    // R6 / R8 read every register back
    for (int i = 0; i < NREG; i++) begin
      xfer({8'h00, 8'h09, 8'(i), 8'h5A}, 24, rd, early, doe);
      chk("R6 read data", rd, model[i]);
      chk("R6 enable over data byte", doe, 8);
      chk("R7 no drive in header", early, 0);
      chk("R7 enable low after select", spi_miso_oe, 0);
    end
    chk_bank("R8 bank unchanged by reads");

    // R5 out-of-range index
    for (int a = 17; a < 256; a += 47) begin
      xfer({8'h00, 8'h08, 8'(a), 8'hC3}, 24, rd, early, doe);
      xfer({8'h00, 8'h09, 8'(a), 8'h00}, 24, rd, early, doe);
      chk("R5 out-of-range read", rd, 0);
      chk("R5 out-of-range read enable", doe, 8);
    end
    chk_bank("R5 bank after out-of-range writes");

    // R4 wrong device byte
    begin
      logic [7:0] badcmd [5] = '{8'h0A, 8'h00, 8'h88, 8'h18, 8'h0C};
      for (int k = 0; k < 5; k++) begin
        xfer({8'h00, badcmd[k], 8'd3, 8'hEE}, 24, rd, early, doe);
        chk("R4 no drive on foreign frame", early + doe, 0);
      end
      xfer({8'h00, 8'h0B, 8'd3, 8'h00}, 24, rd, early, doe);
      chk("R4 no drive on foreign read", early + doe, 0);
    end
    chk_bank("R4 bank after foreign frames");

    // R3 short and long frames
    xfer({8'h00, 8'h08, 8'd4, 8'h77} >> 1, 23, rd, early, doe);
    chk("R3 short frame", cfg_regs[4*8 +: 8], model[4]);
    xfer({7'h00, 8'h08, 8'd4, 8'h77, 1'b1}, 25, rd, early, doe);
    chk("R3 long frame", cfg_regs[4*8 +: 8], model[4]);
    xfer({8'h00, 8'h08, 8'd5, 8'h66}, 16, rd, early, doe);
    chk_bank("R3 bank after bad lengths");

    // R2 a good frame still works afterwards
    xfer({8'h00, 8'h08, 8'd16, 8'hA5}, 24, rd, early, doe);
    model[16] = 8'hA5;
    chk("R2 write after bad frames", cfg_regs[16*8 +: 8], 8'hA5);
    xfer({8'h00, 8'h09, 8'd16, 8'h00}, 24, rd, early, doe);
    chk("R6 read after write", rd, 8'hA5);

    done = 1;
    $display("%0d/%0d checks passed", tot - bad, tot);
    $finish;
  end
endmodule